// File: doc/BRIEF.md
# Prescaled Wakeup Timer

This block is a free-running 32-bit up-counter for an always-on power domain. Software programs a divide ratio and a compare value through a simple single-cycle register port, then sets the run bit. The counter advances by one every (divide + 1) clock cycles. Once the count has reached or passed the compare value, each further count step sets an interrupt status bit and a sticky wakeup-cause flag. The flag drives the wakeup request line to the power manager.

The divider is a two-state machine. `ST_IDLE` is the stopped state: the divide counter is held at zero and no step is issued. `ST_COUNT` is the running state: the divide counter climbs each cycle and issues a step when it reaches the divide value. The transition `go` (IDLE to COUNT) is taken on the first edge at which the run bit is seen set. The transition `halt` (COUNT to IDLE) is taken on the first edge at which the run bit is seen clear. While the run bit is clear, no step is issued in either state.

Software may overwrite the live count at any time. The interrupt status is cleared by writing 1 to it, and it can be forced by a test write. The wakeup-cause flag is cleared only by writing 0 to it.

Top module: `wake_timer`

## Requirements
- R1: After reset, every register reads 0, and `irq_o` and `wake_o` are low.
- R2: The control register (address 0) holds the run bit in bit 0 and the 12-bit divide value in bits 12:1. Bits 31:13 read as 0.
- R3: While the run bit is 0, the count holds its value unless software writes it.
- R4: Take the write that sets the run bit from a stopped state as edge 0. Then after K further edges (K >= 1) the count has grown by floor((K-1)/(divide+1)). The divide counter restarts from 0 after every stop.
- R5: A write to address 2 loads the count. The loaded value wins over a same-cycle count step.
- R6: The compare value is read/write at address 1. A count step taken while count >= compare sets the status bit (address 3, bit 0) and the cause flag (address 5, bit 0) on that edge.
- R7: Writing 1 to address 3 bit 0 clears the status bit and writing 0 has no effect. A same-cycle set wins over the clear.
- R8: Writing 1 to address 4 bit 0 sets the status bit but not the cause flag. Address 4 always reads 0.
- R9: The cause flag is sticky. Only a write of 0 to address 5 bit 0 clears it, and a write of 1 has no effect.
- R10: `irq_o` equals the status bit and `wake_o` equals the cause flag.
- R11: If the divide value is lowered below the divide counter's present value while running, a step is issued on the next cycle and there is no wrap-around wait. Addresses 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Expiry interrupt |
| wake_o | output | 1 | Wakeup request to the power manager |

## Verification
The count rate is tried with divide values 0, 2 and 1, with a stop/start sequence, and with a divide value lowered from 200 to 1 mid-run. Together these separate a correct rate from off-by-one step timing, from a divide counter that survives a stop, and from an equality-only compare that would wrap through 4096. Expiry is approached from just below the compare value, so the cycle before the hit and the hit itself are told apart. The status and cause writes are tried with both data values, with a test force and with a clear during a live hit. These separate clear-on-one from clear-on-zero, and set-wins from clear-wins.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

    localparam int WKT_DW    = 32;
    localparam int WKT_PRE_W = 12;
    localparam int WKT_AW    = 3;

    typedef enum logic [WKT_AW-1:0] {
        A_CTRL  = 3'd0,
        A_CMP   = 3'd1,
        A_COUNT = 3'd2,
        A_STAT  = 3'd3,
        A_TEST  = 3'd4,
        A_CAUSE = 3'd5
    } wkt_addr_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } wkt_state_e;

endpackage

// File: rtl/wkt_divider.sv
module wkt_divider
    import wkt_pkg::*;
#(
    parameter int PRE_W = WKT_PRE_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [PRE_W-1:0] divide_i,
    output logic             step_o
);

    wkt_state_e       state_q, state_d;
    logic [PRE_W-1:0] div_q, div_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            div_q   <= '0;
        end else begin
            state_q <= state_d;
            div_q   <= div_d;
        end
    end

    // transitions: go (IDLE->COUNT), halt (COUNT->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_i)  state_d = ST_COUNT;
            ST_COUNT: if (!run_i) state_d = ST_IDLE;
        endcase
    end

    // outputs and divide counter
    always_comb begin
        step_o = 1'b0;
        div_d  = '0;
        unique case (state_q)
            ST_IDLE: div_d = '0;
            ST_COUNT: begin
                if (run_i) begin
                    if (div_q >= divide_i) begin
                        step_o = 1'b1;
                    end else begin
                        div_d = div_q + 1'b1;
                    end
                end
            end
        endcase
    end

    // R4: a non-zero divide never yields two steps back to back
    assert_no_double_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_o && divide_i != '0) |=> (!step_o || divide_i == '0));

    // R11: a lowered divide below the running count steps at once
    assert_shrink_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_COUNT && run_i && $stable(divide_i) && $past(div_q) > divide_i
         && !$past(step_o)) |-> step_o);

endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          step_i,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    input  logic [DW-1:0] compare_i,
    output logic [DW-1:0] count_o,
    output logic          hit_o
);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (step_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;
    assign hit_o   = step_i && (cnt_q >= compare_i);

    // R3: no step and no load leaves the count alone
    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !load_i) |=> cnt_q == $past(cnt_q));

    // R4: a step adds exactly one
    assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i) |=> cnt_q == DW'($past(cnt_q) + 1'b1));

    // R5: a load wins over a step
    assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> cnt_q == $past(load_val_i));

endmodule

// File: rtl/wkt_flags.sv
module wkt_flags (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    input  logic test_set_i,
    input  logic stat_clr_i,
    input  logic cause_clr_i,
    output logic status_o,
    output logic cause_o
);

    logic stat_q, cause_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q  <= 1'b0;
            cause_q <= 1'b0;
        end else begin
            if (hit_i || test_set_i) begin
                stat_q <= 1'b1;
            end else if (stat_clr_i) begin
                stat_q <= 1'b0;
            end
            if (hit_i) begin
                cause_q <= 1'b1;
            end else if (cause_clr_i) begin
                cause_q <= 1'b0;
            end
        end
    end

    assign status_o = stat_q;
    assign cause_o  = cause_q;

    // R6: a hit always leaves the status set
    assert_hit_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_i |=> stat_q);

    // R7: an uncontested clear drops the status
    assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_clr_i && !hit_i && !test_set_i) |=> !stat_q);

    // R8: without a hit the cause cannot rise
    assert_test_no_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cause_q && !hit_i) |=> !cause_q);

    // R9: the cause only falls on its clear
    assert_cause_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_q && !cause_clr_i) |=> cause_q);

endmodule

// File: rtl/wake_timer.sv
module wake_timer
    import wkt_pkg::*;
#(
    parameter int DW    = WKT_DW,
    parameter int PRE_W = WKT_PRE_W,
    parameter int AW    = WKT_AW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          reg_we_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          irq_o,
    output logic          wake_o
);

    localparam int CTRL_PAD = DW - PRE_W - 1;

    logic             run_q;
    logic [PRE_W-1:0] divide_q;
    logic [DW-1:0]    compare_q;
    logic [DW-1:0]    count;
    logic             step, hit, status, cause;
    logic             wr_ctrl, wr_cmp, wr_count, wr_stat, wr_test, wr_cause;

    always_comb begin
        wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);
        wr_cmp   = reg_we_i && (reg_addr_i == A_CMP);
        wr_count = reg_we_i && (reg_addr_i == A_COUNT);
        wr_stat  = reg_we_i && (reg_addr_i == A_STAT);
        wr_test  = reg_we_i && (reg_addr_i == A_TEST);
        wr_cause = reg_we_i && (reg_addr_i == A_CAUSE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q     <= 1'b0;
            divide_q  <= '0;
            compare_q <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q    <= reg_wdata_i[0];
                divide_q <= reg_wdata_i[PRE_W:1];
            end
            if (wr_cmp) begin
                compare_q <= reg_wdata_i;
            end
        end
    end

    wkt_divider #(.PRE_W(PRE_W)) u_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_q),
        .divide_i (divide_q),
        .step_o   (step)
    );

    wkt_counter #(.DW(DW)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (step),
        .load_i     (wr_count),
        .load_val_i (reg_wdata_i),
        .compare_i  (compare_q),
        .count_o    (count),
        .hit_o      (hit)
    );

    wkt_flags u_flags (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hit_i       (hit),
        .test_set_i  (wr_test && reg_wdata_i[0]),
        .stat_clr_i  (wr_stat && reg_wdata_i[0]),
        .cause_clr_i (wr_cause && !reg_wdata_i[0]),
        .status_o    (status),
        .cause_o     (cause)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            A_CTRL:  reg_rdata_o = {{CTRL_PAD{1'b0}}, divide_q, run_q};
            A_CMP:   reg_rdata_o = compare_q;
            A_COUNT: reg_rdata_o = count;
            A_STAT:  reg_rdata_o = {{(DW-1){1'b0}}, status};
            A_CAUSE: reg_rdata_o = {{(DW-1){1'b0}}, cause};
            default: reg_rdata_o = '0;
        endcase
    end

    assign irq_o  = status;
    assign wake_o = cause;

    // R3: a stopped timer never steps on the cycle after the stop is seen
    assert_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_q && !$past(run_q)) |-> !step);

endmodule

// File: tb/tb_wake_timer.sv
module tb_wake_timer;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_WT = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 77;

    localparam vec_t VECS [NV] = '{
        '{OP_RD, 3'd0, 32'd0,          32'd0,      4'd1},  // R1
        '{OP_RD, 3'd2, 32'd0,          32'd0,      4'd1},
        '{OP_WR, 3'd2, 32'd10,         32'd0,      4'd5},  // R5 load
        '{OP_RD, 3'd2, 32'd0,          32'd10,     4'd5},
        '{OP_WR, 3'd1, 32'h20,         32'd0,      4'd6},  // R6 compare
        '{OP_RD, 3'd1, 32'd0,          32'h20,     4'd6},
        '{OP_WR, 3'd0, 32'hFFFF_FFFE,  32'd0,      4'd2},  // R2 layout
        '{OP_RD, 3'd0, 32'd0,          32'h1FFE,   4'd2},
        '{OP_WT, 3'd0, 32'd5,          32'd0,      4'd3},
        '{OP_RD, 3'd2, 32'd0,          32'd10,     4'd3},  // R3 hold
        '{OP_WR, 3'd0, 32'd1,          32'd0,      4'd4},  // divide 0
        '{OP_WT, 3'd0, 32'd5,          32'd0,      4'd4},
        '{OP_RD, 3'd2, 32'd0,          32'd14,     4'd4},  // R4
        '{OP_WR, 3'd0, 32'd0,          32'd0,      4'd4},
        '{OP_RD, 3'd2, 32'd0,          32'd15,     4'd4},
        '{OP_WT, 3'd0, 32'd4,          32'd0,      4'd3},
        '{OP_RD, 3'd2, 32'd0,          32'd15,     4'd3},  // R3
        '{OP_WR, 3'd0, 32'd5,          32'd0,      4'd4},  // divide 2
        '{OP_WT, 3'd0, 32'd7,          32'd0,      4'd4},
        '{OP_RD, 3'd2, 32'd0,          32'd17,     4'd4},
        '{OP_WR, 3'd0, 32'd401,        32'd0,      4'd11}, // divide 200
        '{OP_WT, 3'd0, 32'd20,         32'd0,      4'd11},
        '{OP_RD, 3'd2, 32'd0,          32'd17,     4'd11},
        '{OP_WR, 3'd0, 32'd3,          32'd0,      4'd11}, // lower to 1
        '{OP_WT, 3'd0, 32'd1,          32'd0,      4'd11},
        '{OP_RD, 3'd2, 32'd0,          32'd18,     4'd11}, // R11
        '{OP_WR, 3'd0, 32'd0,          32'd0,      4'd4},
        '{OP_RD, 3'd2, 32'd0,          32'd18,     4'd4},
        '{OP_WR, 3'd0, 32'd3,          32'd0,      4'd4},  // restart
        '{OP_WT, 3'd0, 32'd2,          32'd0,      4'd4},
        '{OP_RD, 3'd2, 32'd0,          32'd18,     4'd4},  // R4 restart
        '{OP_WT, 3'd0, 32'd1,          32'd0,      4'd4},
        '{OP_RD, 3'd2, 32'd0,          32'd19,     4'd4},
        '{OP_WR, 3'd0, 32'd0,          32'd0,      4'd4},
        '{OP_RD, 3'd2, 32'd0,          32'd19,     4'd4},
        '{OP_RD, 3'd3, 32'd0,          32'd0,      4'd6},
        '{OP_WR, 3'd2, 32'd30,         32'd0,      4'd5},
        '{OP_WR, 3'd0, 32'd1,          32'd0,      4'd6},
        '{OP_WT, 3'd0, 32'd3,          32'd0,      4'd6},
        '{OP_RD, 3'd3, 32'd0,          32'd0,      4'd6},  // R6 not yet
        '{OP_RD, 3'd5, 32'd0,          32'd0,      4'd6},
        '{OP_WT, 3'd0, 32'd1,          32'd0,      4'd6},
        '{OP_RD, 3'd3, 32'd0,          32'd1,      4'd6},  // R6 hit
        '{OP_RD, 3'd5, 32'd0,          32'd1,      4'd6},
        '{OP_WR, 3'd0, 32'd0,          32'd0,      4'd6},
        '{OP_RD, 3'd2, 32'd0,          32'd34,     4'd4},
        '{OP_WR, 3'd3, 32'd0,          32'd0,      4'd7},  // R7 write 0
        '{OP_RD, 3'd3, 32'd0,          32'd1,      4'd7},
        '{OP_WR, 3'd3, 32'd1,          32'd0,      4'd7},
        '{OP_RD, 3'd3, 32'd0,          32'd0,      4'd7},
        '{OP_RD, 3'd5, 32'd0,          32'd1,      4'd9},  // R9 sticky
        '{OP_WR, 3'd5, 32'd1,          32'd0,      4'd9},
        '{OP_RD, 3'd5, 32'd0,          32'd1,      4'd9},
        '{OP_WR, 3'd5, 32'd0,          32'd0,      4'd9},
        '{OP_RD, 3'd5, 32'd0,          32'd0,      4'd9},
        '{OP_WR, 3'd4, 32'd1,          32'd0,      4'd8},  // R8 force
        '{OP_RD, 3'd3, 32'd0,          32'd1,      4'd8},
        '{OP_RD, 3'd5, 32'd0,          32'd0,      4'd8},
        '{OP_RD, 3'd4, 32'd0,          32'd0,      4'd8},
        '{OP_WR, 3'd3, 32'd1,          32'd0,      4'd7},
        '{OP_RD, 3'd3, 32'd0,          32'd0,      4'd7},
        '{OP_RD, 3'd6, 32'd0,          32'd0,      4'd11}, // unused
        '{OP_WR, 3'd7, 32'hFFFF_FFFF,  32'd0,      4'd11},
        '{OP_RD, 3'd0, 32'd0,          32'd0,      4'd11},
        '{OP_RD, 3'd1, 32'd0,          32'h20,     4'd11},
        '{OP_WR, 3'd1, 32'd0,          32'd0,      4'd6},
        '{OP_WR, 3'd0, 32'd1,          32'd0,      4'd7},
        '{OP_WT, 3'd0, 32'd3,          32'd0,      4'd7},
        '{OP_WR, 3'd3, 32'd1,          32'd0,      4'd7},  // R7 set wins
        '{OP_RD, 3'd3, 32'd0,          32'd1,      4'd7},
        '{OP_WR, 3'd2, 32'd100,        32'd0,      4'd5},  // R5 priority
        '{OP_RD, 3'd2, 32'd0,          32'd100,    4'd5},
        '{OP_WR, 3'd0, 32'd0,          32'd0,      4'd4},
        '{OP_RD, 3'd2, 32'd0,          32'd101,    4'd4},
        '{OP_WR, 3'd3, 32'd1,          32'd0,      4'd7},
        '{OP_RD, 3'd3, 32'd0,          32'd0,      4'd7},
        '{OP_RD, 3'd5, 32'd0,          32'd1,      4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wake_timer dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    task automatic do_write(input logic [2:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic check_read(input logic [2:0] a, input logic [31:0] e, input string tag);
        addr = a;
        #1;
        checks++;
        if (rdata !== e) begin
            fails++;
            $display("FAIL %s: addr %0d read 0x%08h expected 0x%08h", tag, a, rdata, e);
        end
    endtask

    task automatic check_pin(input logic got, input logic e, input string tag);
        checks++;
        if (got !== e) begin
            fails++;
            $display("FAIL %s: pin %0b expected %0b", tag, got, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_pin(irq, 1'b0, "R1 irq after reset");
        check_pin(wake, 1'b0, "R1 wake after reset");

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].op)
                OP_WR: do_write(VECS[i].addr, VECS[i].data);
                OP_RD: check_read(VECS[i].addr, VECS[i].expv,
                                  $sformatf("R%0d vector %0d", VECS[i].req, i));
                default: repeat (int'(VECS[i].data)) @(negedge clk);
            endcase
        end

        // R10: pins follow status and cause
        check_pin(irq, 1'b0, "R10 irq after clear");
        check_pin(wake, 1'b1, "R10 wake while cause set");
        do_write(3'd4, 32'd1);
        check_pin(irq, 1'b1, "R10 irq after force");
        do_write(3'd5, 32'd0);
        check_pin(wake, 1'b0, "R10 wake after cause clear");

        // R1: reset in the middle of a run
        do_write(3'd0, 32'd1);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            check_read(3'(a), 32'd0, "R1 register after reset");
        end
        check_pin(irq, 1'b0, "R1 irq after mid-run reset");
        check_pin(wake, 1'b0, "R1 wake after mid-run reset");
        repeat (3) @(negedge clk);
        check_read(3'd2, 32'd0, "R3 count stays stopped after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule